// File: doc/BRIEF.md
# Rate-Trimmed Watch Timebase

This block turns a 32768 Hz crystal clock into the slow time references of a watch: a 8192 Hz advance strobe, a 32 Hz monitor square wave (the oscillator frequency divided by 1024), a 1 Hz square wave and a strobe marking each trim interval. A crystal that runs fast is trimmed digitally. At the start of every trim interval of one or two minutes, the block swallows a programmed number n (0 to 127) of consecutive 8192 Hz pulses. Everything downstream of that stage therefore loses exactly n/8192 s per interval. One step is worth roughly 2.03 ppm with the one-minute interval and about 1.017 ppm with the two-minute interval.

The 8-bit trim word is read at each interval boundary. A measurement mode applies the same n-pulse deletion at the start of every monitor period instead of once per interval. The monitor period then becomes 31.25 ms plus n times 122 µs, so a frequency counter can read the programmed trim directly.

Top module: `cal_timebase`

## Requirements
- R1: While reset is high and on the first cycle after it, every output is low. After reset falls, the first trim strobe appears after exactly SECS_PER_INTV·2^SEC_W advances, with no deletion.
- R2: With no deletion pending, the advance strobe `tick_o` pulses once every 2^PRE_W clocks. It is 4 oscillator cycles at defaults, which gives 8192 Hz. Every trim strobe coincides with an advance.
- R3: The trim word is split as follows. `cal_i[7:1]` is the deletion count n, with `cal_i[7]` as the most significant bit. `cal_i[0]` selects the interval: 0 gives SECS_PER_INTV seconds and 1 gives twice that.
- R4: A trim interval spans SECS_PER_INTV·2^SEC_W advances, or twice that when `cal_i[0]`=1. `intv_o` is a one-cycle strobe at each boundary.
- R5: Right after a boundary, the next n prescaler pulses are swallowed. The clocks between two consecutive `intv_o` strobes equal (advances per interval + n)·2^PRE_W.
- R6: Swallowing pulses never drops counts from the chain. Exactly the nominal number of advances occurs between two strobes.
- R7: With n=0, no pulse is swallowed and the interval is exactly nominal.
- R8: `mon_o` is a square wave with a period of 2^(SEC_W-5) advances. At defaults this is the oscillator frequency divided by 1024.
- R9: `hz1_o` is a square wave with a period of 2^SEC_W advances. It rises once per second, which means once or twice per interval for the two interval lengths.
- R10: With `meas_i`=1, n pulses are swallowed at the start of every monitor period. The distance between rising edges of `mon_o` is then (2^(SEC_W-5)+n)·2^PRE_W clocks.
- R11: The count n is taken only at a boundary. A change to n in mid-interval affects the next interval, not the current one.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Oscillator clock |
| rst | input | 1 | Synchronous active-high reset |
| cal_i | input | 8 | Trim word: deletion count and interval select |
| meas_i | input | 1 | 1 = swallow n pulses every monitor period |
| tick_o | output | 1 | Advance strobe of the 8192 Hz stage after deletion |
| mon_o | output | 1 | Monitor square wave |
| hz1_o | output | 1 | 1 Hz square wave |
| intv_o | output | 1 | One-cycle strobe at each trim-interval boundary |

## Verification
The bench builds the block with PRE_W=1, SEC_W=7 and SECS_PER_INTV=1. A "minute" is therefore 128 advances and a monitor period is 4 advances. Because 128 exceeds the largest count, every n from 0 to 127 can be applied in the single-interval mode within a short run, and each interval length is predicted arithmetically. The double-length interval and the measurement mode are swept over spaced values of n that include both ends. The reset-to-first-strobe delay, the mid-interval change of n, and the tick and monitor spacing are each checked cycle-exactly.

// File: rtl/tbase_pkg.sv
package tbase_pkg;
  // monitor period is 2^-MON_LOG2 of a second
  localparam int MON_LOG2 = 5;
  typedef enum logic {INTV_SINGLE = 1'b0, INTV_DOUBLE = 1'b1} intv_sel_e;
endpackage

// File: rtl/tb_prescale.sv
module tb_prescale #(
  parameter int PRE_W = 2
) (
  input  logic clk,
  input  logic rst,
  output logic pre_tick_o
);
  generate
    if (PRE_W == 0) begin : g_bypass
      assign pre_tick_o = 1'b1;
    end else begin : g_div
      logic [PRE_W-1:0] div_q;
      always_ff @(posedge clk) begin
        if (rst) div_q <= '0;
        else     div_q <= div_q + 1'b1;
      end
      assign pre_tick_o = &div_q;

      // R2
      tick_gap_chk: assert property (@(posedge clk) disable iff (rst)
        pre_tick_o |=> !pre_tick_o);
    end
  endgenerate
endmodule

// File: rtl/tb_inhibit.sv
module tb_inhibit #(
  parameter int N_W = 7
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           pre_tick_i,
  input  logic           load_i,
  input  logic [N_W-1:0] n_i,
  output logic           adv_o
);
  logic [N_W-1:0] inh_q;

  always_ff @(posedge clk) begin
    if (rst)                              inh_q <= '0;
    else if (load_i)                      inh_q <= n_i;
    else if (pre_tick_i && inh_q != '0)   inh_q <= inh_q - 1'b1;
  end

  assign adv_o = pre_tick_i && (inh_q == '0);

  // R5
  hold_inh_chk: assert property (@(posedge clk) disable iff (rst)
    (!pre_tick_i && !load_i) |=> $stable(inh_q));
endmodule

// File: rtl/tb_chain.sv
module tb_chain #(
  parameter int SEC_W = 13
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             adv_i,
  output logic [SEC_W-1:0] cnt_o,
  output logic             sec_wrap_o,
  output logic             frame_wrap_o
);
  localparam int FW = SEC_W - tbase_pkg::MON_LOG2;

  logic [SEC_W-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst)        cnt_q <= '0;
    else if (adv_i) cnt_q <= cnt_q + 1'b1;
  end

  assign cnt_o        = cnt_q;
  assign sec_wrap_o   = adv_i && (&cnt_q);
  assign frame_wrap_o = adv_i && (&cnt_q[FW-1:0]);

  // R6
  cnt_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !adv_i |=> $stable(cnt_q));
endmodule

// File: rtl/tb_interval.sv
module tb_interval #(
  parameter int SECS = 60
) (
  input  logic clk,
  input  logic rst,
  input  logic sec_wrap_i,
  input  logic dbl_i,
  output logic wrap_o
);
  localparam int SW = (2 * SECS > 1) ? $clog2(2 * SECS) : 1;
  localparam logic [SW-1:0] LAST_S = SW'(SECS - 1);
  localparam logic [SW-1:0] LAST_D = SW'(2 * SECS - 1);

  logic [SW-1:0] sec_q;
  logic [SW-1:0] last;

  assign last   = dbl_i ? LAST_D : LAST_S;
  assign wrap_o = sec_wrap_i && (sec_q >= last);

  always_ff @(posedge clk) begin
    if (rst)             sec_q <= '0;
    else if (wrap_o)     sec_q <= '0;
    else if (sec_wrap_i) sec_q <= sec_q + 1'b1;
  end

  // R4
  sec_range_chk: assert property (@(posedge clk) disable iff (rst)
    sec_q <= LAST_D);
endmodule

// File: rtl/cal_timebase.sv
module cal_timebase #(
  parameter int PRE_W         = 2,
  parameter int SEC_W         = 13,
  parameter int SECS_PER_INTV = 60
) (
  input  logic       clk,
  input  logic       rst,
  input  logic [7:0] cal_i,
  input  logic       meas_i,
  output logic       tick_o,
  output logic       mon_o,
  output logic       hz1_o,
  output logic       intv_o
);
  localparam int N_W     = 7;
  localparam int MON_BIT = SEC_W - tbase_pkg::MON_LOG2 - 1;

  logic             pre_tick, adv, load;
  logic             sec_wrap, frame_wrap, intv_wrap;
  logic [SEC_W-1:0] cnt;
  tbase_pkg::intv_sel_e sel;

  assign sel  = tbase_pkg::intv_sel_e'(cal_i[0]);
  assign load = meas_i ? frame_wrap : intv_wrap;

  tb_prescale #(.PRE_W(PRE_W)) u_pre (
    .clk(clk), .rst(rst), .pre_tick_o(pre_tick));

  tb_inhibit #(.N_W(N_W)) u_inh (
    .clk(clk), .rst(rst), .pre_tick_i(pre_tick), .load_i(load),
    .n_i(cal_i[7:1]), .adv_o(adv));

  tb_chain #(.SEC_W(SEC_W)) u_chain (
    .clk(clk), .rst(rst), .adv_i(adv), .cnt_o(cnt),
    .sec_wrap_o(sec_wrap), .frame_wrap_o(frame_wrap));

  tb_interval #(.SECS(SECS_PER_INTV)) u_intv (
    .clk(clk), .rst(rst), .sec_wrap_i(sec_wrap),
    .dbl_i(sel == tbase_pkg::INTV_DOUBLE), .wrap_o(intv_wrap));

  always_ff @(posedge clk) begin
    if (rst) begin
      tick_o <= 1'b0;
      intv_o <= 1'b0;
    end else begin
      tick_o <= adv;
      intv_o <= intv_wrap;
    end
  end

  assign mon_o = cnt[MON_BIT];
  assign hz1_o = cnt[SEC_W-1];

  // R4
  intv_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    intv_o |=> !intv_o);
  // R2
  intv_on_tick_chk: assert property (@(posedge clk) disable iff (rst)
    intv_o |-> tick_o);
endmodule

// File: tb/cal_timebase_bench.sv
module cal_timebase_bench;
  localparam int PRE_W = 1;
  localparam int SEC_W = 7;
  localparam int SECS  = 1;
  localparam int TPS   = 1 << SEC_W;            // advances per second
  localparam int FRAME = 1 << (SEC_W - 5);      // advances per monitor period
  localparam int CPT   = 1 << PRE_W;            // clocks per advance

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [7:0] cal = 8'h00;
  logic meas = 1'b0;
  logic tick_o, mon_o, hz1_o, intv_o;

  int vectors = 0;
  int errors  = 0;

  always #5 clk = ~clk;

  cal_timebase #(.PRE_W(PRE_W), .SEC_W(SEC_W), .SECS_PER_INTV(SECS)) u_cal_timebase (
    .clk(clk), .rst(rst), .cal_i(cal), .meas_i(meas),
    .tick_o(tick_o), .mon_o(mon_o), .hz1_o(hz1_o), .intv_o(intv_o));

  task automatic check(input bit ok, input string req, input int act, input int exp);
    vectors++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic sync_intv();
    do @(negedge clk); while (!intv_o);
  endtask

  task automatic measure(output int clks, output int tks, output int secs);
    logic prev;
    clks = 0; tks = 0; secs = 0; prev = hz1_o;
    do begin
      @(negedge clk);
      clks++;
      if (tick_o) tks++;
      if (hz1_o && !prev) secs++;
      prev = hz1_o;
    end while (!intv_o);
  endtask

  task automatic mon_period(output int clks);
    logic prev;
    prev = mon_o;
    forever begin
      @(negedge clk);
      if (mon_o && !prev) break;
      prev = mon_o;
    end
    clks = 0;
    prev = mon_o;
    forever begin
      @(negedge clk);
      clks++;
      if (mon_o && !prev) break;
      prev = mon_o;
    end
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    errors++;
    vectors++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("  == %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end

  initial begin
    int c, t, s, gap, k, first;
    // R1 outputs low in reset
    repeat (3) @(negedge clk);
    check({tick_o, mon_o, hz1_o, intv_o} == 4'b0, "R1 reset", {tick_o, mon_o, hz1_o, intv_o}, 0);
    rst = 1'b0;
    first = 0;
    k = 0;
    do begin
      @(negedge clk);
      k++;
      if (k == 1) check({tick_o, mon_o, hz1_o, intv_o} == 4'b0, "R1 first cycle", {tick_o, mon_o, hz1_o, intv_o}, 0);
    end while (!intv_o && k < 5000);
    first = k;
    // R1 R4 first boundary after SECS*TPS undeleted advances
    check(first == SECS * TPS * CPT, "R1 first strobe", first, SECS * TPS * CPT);

    // R2 tick spacing with nothing pending
    for (int i = 0; i < 4; i++) begin
      gap = 0;
      do begin @(negedge clk); gap++; end while (!tick_o);
      check(gap == CPT, "R2 tick spacing", gap, CPT);
    end

    // R8 monitor period in normal mode, n=0
    for (int i = 0; i < 3; i++) begin
      mon_period(c);
      check(c == FRAME * CPT, "R8 monitor period", c, FRAME * CPT);
    end

    // R3 R5 R6 R7 R9 single interval, every n
    for (int n = 0; n < 128; n++) begin
      cal = {n[6:0], 1'b0};
      sync_intv();
      measure(c, t, s);
      check(c == (SECS * TPS + n) * CPT, n == 0 ? "R7 R5 interval clocks" : "R5 interval clocks",
            c, (SECS * TPS + n) * CPT);
      check(t == SECS * TPS, "R6 advances per interval", t, SECS * TPS);
      if (n % 16 == 0) check(s == SECS, "R9 seconds per interval", s, SECS);
    end

    // R11 mid-interval change of n
    cal = {7'd20, 1'b0};
    sync_intv();
    @(negedge clk);
    cal = {7'd3, 1'b0};
    measure(c, t, s);
    check(c == (SECS * TPS + 20) * CPT - 1, "R11 current interval keeps n", c, (SECS * TPS + 20) * CPT - 1);
    measure(c, t, s);
    check(c == (SECS * TPS + 3) * CPT, "R11 next interval takes n", c, (SECS * TPS + 3) * CPT);

    // R3 R4 double interval
    for (int n = 0; n < 128; n += 9) begin
      cal = {n[6:0], 1'b1};
      sync_intv();
      measure(c, t, s);
      check(c == (2 * SECS * TPS + n) * CPT, "R4 double interval clocks", c, (2 * SECS * TPS + n) * CPT);
      check(t == 2 * SECS * TPS, "R6 double advances", t, 2 * SECS * TPS);
      check(s == 2 * SECS, "R9 double seconds", s, 2 * SECS);
    end
    cal = {7'd127, 1'b1};
    sync_intv();
    measure(c, t, s);
    check(c == (2 * SECS * TPS + 127) * CPT, "R4 double interval n=127", c, (2 * SECS * TPS + 127) * CPT);

    // R10 measurement mode
    meas = 1'b1;
    for (int n = 0; n < 128; n += 3) begin
      cal = {n[6:0], 1'b0};
      mon_period(c);
      check(c == (FRAME + n) * CPT, "R10 measurement period", c, (FRAME + n) * CPT);
    end
    cal = {7'd127, 1'b0};
    mon_period(c);
    check(c == (FRAME + 127) * CPT, "R10 measurement n=127", c, (FRAME + 127) * CPT);

    $display("  == %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end
endmodule